// File: doc/BRIEF.md
# PIO Strobe Timing Generator

This block sequences one programmed-I/O task-file access on a disk channel. A start request carries a direction (read or write) and a drive index. The block looks up that drive's timing for that direction from packed configuration vectors. It then runs three phases, all counted in bus clocks: address setup, an active-low command strobe, and recovery. Busy is high for the whole access.

Each drive has its own 2-bit setup count. Each drive also has one timing byte for reads and another for writes. In each byte the high nibble is the strobe width and the low nibble is the recovery count. A per-drive enhanced-mode code can replace the strobe width with a fixed width.

A request that arrives while a cycle is running is held, one deep. It starts in the clock right after the running cycle's recovery ends, so no idle clock appears between the two.

Top module: `pio_strobe_gen`

## Requirements
- R1: During and directly after reset, `busy_o` and `addr_valid_o` are low and both strobes are high.
- R2: A start accepted at edge k gives `addr_valid_o` high from the next cycle. The strobe then begins after S cycles. S is `setup_i[2d+1:2d]` for drive d. S=0 means the strobe begins in the first cycle.
- R3: The strobe is low for P+1 consecutive cycles. P is bits [7:4] of byte d of the selected timing vector. `addr_valid_o` stays high through the strobe and drops when it ends.
- R4: After the strobe come Rc+1 recovery cycles. Rc is bits [3:0] of that same byte. During recovery `busy_o` is high, `addr_valid_o` is low and both strobes are high.
- R5: `wr_i`=0 selects `rd_tim_i` and pulses `rd_strobe_no`. `wr_i`=1 selects `wr_tim_i` and pulses `wr_strobe_no`. The two strobes are never low together.
- R6: Drive d uses byte d (bits [8d+7:8d]) of the timing vectors and setup field d. The other drive's fields have no effect.
- R7: The enhanced code m sits at `emode_i[4c+2d+1:4c+2d]`, where c is the CHAN parameter (0 by default). When m is nonzero the strobe is low for 4-m cycles and P is ignored. Setup and recovery still come from the fields. When m is 0, P is used. Codes that belong to the other channel have no effect.
- R8: `busy_o` is high from the cycle after acceptance for exactly S+W+Rc+1 cycles, where W is the strobe width.
- R9: A start that arrives while busy is held. This includes a start sampled at the last recovery edge. The held cycle begins in the very next cycle, so `busy_o` stays high and the second cycle's setup directly follows the first cycle's recovery.
- R10: Only one request is held. Further starts while one is already held are dropped, and no extra strobe appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one access |
| wr_i | input | 1 | Direction of the request: 1 write, 0 read |
| drv_i | input | DW (1) | Drive index of the request |
| rd_tim_i | input | NDRV*2*NW (16) | Read timing bytes per drive: {pulse, recovery} |
| wr_tim_i | input | NDRV*2*NW (16) | Write timing bytes per drive: {pulse, recovery} |
| setup_i | input | NDRV*SW (4) | Address setup count per drive |
| emode_i | input | NCH*NDRV*2 (8) | Enhanced-mode codes per channel and drive |
| busy_o | output | 1 | An access is in progress |
| addr_valid_o | output | 1 | Address phase (setup and strobe) |
| rd_strobe_no | output | 1 | Read strobe, active low |
| wr_strobe_no | output | 1 | Write strobe, active low |

## Verification
A wrong phase counter or a wrong load value shows at the ports within a single access. It appears as a setup, strobe or busy run that is a few clocks longer or shorter than the selected fields imply, and the error is visible as soon as that phase ends. A wrong field selection has the same symptom: the strobe width follows a decoy value that was placed in the other drive's byte, in the other direction's register, or in the other channel's mode bits. A broken holding register shows in the next few tens of clocks, as a gap in busy, a late second strobe, or a third strobe where two were due.

// File: rtl/pio_strobe_pkg.sv
package pio_strobe_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_RECOV  = 2'd3
  } phase_e;

  // strobe width for a nonzero enhanced code is 4-m clocks; returns width-1
  function automatic logic [1:0] enh_pulse_load(input logic [1:0] m);
    return 2'd3 - m;
  endfunction
endpackage

// File: rtl/pio_tim_sel.sv
module pio_tim_sel
  import pio_strobe_pkg::*;
#(
  parameter int NDRV   = 2,
  parameter int NCH    = 2,
  parameter int CHAN   = 0,
  parameter int NW     = 4,
  parameter int SW     = 2,
  parameter bit ENH_EN = 1'b1,
  localparam int DW    = (NDRV > 1) ? $clog2(NDRV) : 1,
  localparam int BW    = 2 * NW
) (
  input  logic [DW-1:0]        drv_i,
  input  logic                 wr_i,
  input  logic [NDRV*BW-1:0]   rd_tim_i,
  input  logic [NDRV*BW-1:0]   wr_tim_i,
  input  logic [NDRV*SW-1:0]   setup_i,
  input  logic [NCH*NDRV*2-1:0] emode_i,
  output logic [SW-1:0]        setup_o,
  output logic [NW-1:0]        pulse_o,
  output logic [NW-1:0]        recov_o
);
  logic [BW-1:0] tim_byte;
  logic [NW-1:0] reg_pulse;

  assign tim_byte  = wr_i ? wr_tim_i[int'(drv_i)*BW +: BW]
                          : rd_tim_i[int'(drv_i)*BW +: BW];
  assign reg_pulse = tim_byte[NW +: NW];
  assign recov_o   = tim_byte[0 +: NW];
  assign setup_o   = setup_i[int'(drv_i)*SW +: SW];

  generate
    if (ENH_EN) begin : g_enh
      logic [1:0] mode;
      assign mode    = emode_i[(CHAN*NDRV + int'(drv_i))*2 +: 2];
      assign pulse_o = (mode != 2'd0) ? NW'(enh_pulse_load(mode)) : reg_pulse;
    end else begin : g_plain
      assign pulse_o = reg_pulse;
    end
  endgenerate
endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
  import pio_strobe_pkg::*;
#(
  parameter int NW  = 4,
  parameter int SW  = 2,
  parameter int DW  = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          wr_i,
  input  logic [DW-1:0] drv_i,
  output logic          src_wr_o,
  output logic [DW-1:0] src_drv_o,
  input  logic [SW-1:0] setup_i,
  input  logic [NW-1:0] pulse_i,
  input  logic [NW-1:0] recov_i,
  output phase_e        phase_o,
  output logic          dir_o
);
  phase_e        ph;
  logic [NW-1:0] cnt, pulse_q, recov_q;
  logic          dir_q, pend_v, pend_wr, done, launch;
  logic [DW-1:0] pend_drv;

  assign src_wr_o  = pend_v ? pend_wr  : wr_i;
  assign src_drv_o = pend_v ? pend_drv : drv_i;
  assign done      = (cnt == '0);
  assign launch    = (ph == PH_IDLE && start_i) ||
                     (ph == PH_RECOV && done && (pend_v || start_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      pulse_q <= '0;
      recov_q <= '0;
      dir_q   <= 1'b0;
    end else if (launch) begin
      dir_q   <= src_wr_o;
      pulse_q <= pulse_i;
      recov_q <= recov_i;
      if (setup_i != '0) begin
        ph  <= PH_SETUP;
        cnt <= NW'(setup_i) - NW'(1);
      end else begin
        ph  <= PH_STROBE;
        cnt <= pulse_i;
      end
    end else begin
      unique case (ph)
        PH_SETUP:  if (done) begin ph <= PH_STROBE; cnt <= pulse_q; end
                   else cnt <= cnt - NW'(1);
        PH_STROBE: if (done) begin ph <= PH_RECOV;  cnt <= recov_q; end
                   else cnt <= cnt - NW'(1);
        PH_RECOV:  if (done) ph <= PH_IDLE;
                   else cnt <= cnt - NW'(1);
        default:   ;
      endcase
    end
  end

  // single-entry hold for requests arriving while busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v   <= 1'b0;
      pend_wr  <= 1'b0;
      pend_drv <= '0;
    end else if (launch) begin
      pend_v <= pend_v && start_i;
      if (pend_v && start_i) begin
        pend_wr  <= wr_i;
        pend_drv <= drv_i;
      end
    end else if (ph != PH_IDLE && start_i && !pend_v) begin
      pend_v   <= 1'b1;
      pend_wr  <= wr_i;
      pend_drv <= drv_i;
    end
  end

  assign phase_o = ph;
  assign dir_o   = dir_q;

  a_r2_setup_to_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph == PH_SETUP && done) |=> (ph == PH_STROBE));
  a_r4_strobe_to_recov: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph == PH_STROBE && done) |=> (ph == PH_RECOV));
  a_r8_start_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph == PH_IDLE && start_i) |=> (ph != PH_IDLE));
  a_r9_pend_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_v |-> (ph != PH_IDLE));
  a_r10_pend_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_v && !launch) |=> (pend_v && $stable(pend_drv) && $stable(pend_wr)));
  a_r5_dir_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph == PH_STROBE && !done) |=> $stable(dir_q));
endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
  import pio_strobe_pkg::*;
#(
  parameter int NDRV   = 2,
  parameter int NCH    = 2,
  parameter int CHAN   = 0,
  parameter int NW     = 4,
  parameter int SW     = 2,
  parameter bit ENH_EN = 1'b1,
  localparam int DW    = (NDRV > 1) ? $clog2(NDRV) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   wr_i,
  input  logic [DW-1:0]          drv_i,
  input  logic [NDRV*2*NW-1:0]   rd_tim_i,
  input  logic [NDRV*2*NW-1:0]   wr_tim_i,
  input  logic [NDRV*SW-1:0]     setup_i,
  input  logic [NCH*NDRV*2-1:0]  emode_i,
  output logic                   busy_o,
  output logic                   addr_valid_o,
  output logic                   rd_strobe_no,
  output logic                   wr_strobe_no
);
  logic          src_wr, dir;
  logic [DW-1:0] src_drv;
  logic [SW-1:0] sel_setup;
  logic [NW-1:0] sel_pulse, sel_recov;
  phase_e        phase;

  pio_tim_sel #(
    .NDRV(NDRV), .NCH(NCH), .CHAN(CHAN), .NW(NW), .SW(SW), .ENH_EN(ENH_EN)
  ) u_sel (
    .drv_i   (src_drv),
    .wr_i    (src_wr),
    .rd_tim_i(rd_tim_i),
    .wr_tim_i(wr_tim_i),
    .setup_i (setup_i),
    .emode_i (emode_i),
    .setup_o (sel_setup),
    .pulse_o (sel_pulse),
    .recov_o (sel_recov)
  );

  pio_phase_seq #(.NW(NW), .SW(SW), .DW(DW)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .wr_i     (wr_i),
    .drv_i    (drv_i),
    .src_wr_o (src_wr),
    .src_drv_o(src_drv),
    .setup_i  (sel_setup),
    .pulse_i  (sel_pulse),
    .recov_i  (sel_recov),
    .phase_o  (phase),
    .dir_o    (dir)
  );

  assign busy_o       = (phase != PH_IDLE);
  assign addr_valid_o = (phase == PH_SETUP) || (phase == PH_STROBE);
  assign rd_strobe_no = !((phase == PH_STROBE) && !dir);
  assign wr_strobe_no = !((phase == PH_STROBE) && dir);

  a_r5_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strobe_no || wr_strobe_no));
  a_r3_strobe_with_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_strobe_no || !wr_strobe_no) |-> (addr_valid_o && busy_o));
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (rd_strobe_no && wr_strobe_no && !addr_valid_o));
endmodule

// File: tb/sim_pio_strobe_gen.sv
module sim_pio_strobe_gen;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        start_i = 1'b0, wr_i = 1'b0;
  logic [0:0]  drv_i = '0;
  logic [15:0] rd_tim_i = '0, wr_tim_i = '0;
  logic [3:0]  setup_i = '0;
  logic [7:0]  emode_i = '0;
  logic        busy_o, addr_valid_o, rd_strobe_no, wr_strobe_no;

  int total = 0, bad = 0;
  int m_busy, m_av, m_pulses, m_plen0, m_plen1, m_first, m_first2, m_rd, m_wr;

  always #2 clk = ~clk;

  pio_strobe_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .wr_i(wr_i), .drv_i(drv_i),
    .rd_tim_i(rd_tim_i), .wr_tim_i(wr_tim_i), .setup_i(setup_i), .emode_i(emode_i),
    .busy_o(busy_o), .addr_valid_o(addr_valid_o),
    .rd_strobe_no(rd_strobe_no), .wr_strobe_no(wr_strobe_no)
  );

  task automatic chk(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // target drive d gets {p,r}; the other byte holds decoy values
  function automatic logic [15:0] tim_vec(int d, int p, int r);
    logic [7:0] tgt, oth;
    tgt = {4'(p), 4'(r)};
    oth = {4'((p + 7) % 16), 4'((r + 5) % 16)};
    return (d == 0) ? {oth, tgt} : {tgt, oth};
  endfunction

  // pulse start at next edge, then observe each cycle; optional injections
  task automatic run(input bit wr, input bit d, input int inj1, input int inj2,
                     input bit wr2, input bit d2);
    bit st, prev;
    @(negedge clk);
    start_i = 1'b1; wr_i = wr; drv_i = d;
    m_busy = 0; m_av = 0; m_pulses = 0; m_plen0 = 0; m_plen1 = 0;
    m_first = -1; m_first2 = -1; m_rd = 0; m_wr = 0; prev = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (!busy_o) break;
      m_busy++;
      if (addr_valid_o) m_av++;
      if (!rd_strobe_no) m_rd++;
      if (!wr_strobe_no) m_wr++;
      st = !rd_strobe_no || !wr_strobe_no;
      if (st && !prev) begin
        m_pulses++;
        if (m_pulses == 1) m_first = i;
        if (m_pulses == 2) m_first2 = i;
      end
      if (st && m_pulses == 1) m_plen0++;
      if (st && m_pulses == 2) m_plen1++;
      prev = st;
      if (i == inj1 || i == inj2) begin
        start_i = 1'b1; wr_i = wr2; drv_i = d2;
      end
    end
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    #5;
    chk(busy_o, 0, "R1 busy in reset");
    chk(addr_valid_o, 0, "R1 addr_valid in reset");
    chk(rd_strobe_no & wr_strobe_no, 1, "R1 strobes in reset");
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk(busy_o | addr_valid_o | !rd_strobe_no | !wr_strobe_no, 0, "R1 idle after reset");

    // R2 R3 R4 R5 R6 R8: sweep over direction, drive, setup, pulse, recovery
    for (int wr = 0; wr < 2; wr++)
      for (int d = 0; d < 2; d++)
        for (int s = 0; s < 4; s++)
          for (int pi = 0; pi < 3; pi++)
            for (int ri = 0; ri < 3; ri++) begin
              int p, r, w;
              p = (pi == 0) ? 0 : (pi == 1) ? 2 : 5;
              r = (ri == 0) ? 0 : (ri == 1) ? 3 : 9;
              w = p + 1;
              emode_i = 8'h00;
              setup_i = (d == 0) ? {2'((s + 1) % 4), 2'(s)} : {2'(s), 2'((s + 1) % 4)};
              if (wr == 1) begin
                wr_tim_i = tim_vec(d, p, r);
                rd_tim_i = tim_vec(d, (p + 3) % 16, (r + 6) % 16);
              end else begin
                rd_tim_i = tim_vec(d, p, r);
                wr_tim_i = tim_vec(d, (p + 3) % 16, (r + 6) % 16);
              end
              run(wr[0], d[0], -1, -1, 1'b0, 1'b0);
              chk(m_first, s, "R2 strobe start after setup");
              chk(m_plen0, w, "R3 strobe width");
              chk(m_av, s + w, "R3 addr_valid span");
              chk(m_busy - s - w, r + 1, "R4 recovery length");
              chk(m_busy, s + w + r + 1, "R8 busy length");
              chk(m_pulses, 1, "R6 single strobe");
              chk(wr ? m_wr : m_rd, w, "R5 strobe on selected line");
              chk(wr ? m_rd : m_wr, 0, "R5 other line idle");
            end

    // R7: enhanced codes override pulse; other channel codes ignored
    for (int d = 0; d < 2; d++)
      for (int m = 0; m < 4; m++) begin
        setup_i = 4'b0101;
        rd_tim_i = {8'h62, 8'h62};
        wr_tim_i = {8'h11, 8'h11};
        emode_i = {4'hF, 4'h0};
        emode_i[d*2 +: 2] = 2'(m);
        emode_i[(1-d)*2 +: 2] = 2'(3 - m);
        run(1'b0, d[0], -1, -1, 1'b0, 1'b0);
        chk(m_plen0, (m == 0) ? 7 : 4 - m, "R7 enhanced strobe width");
        chk(m_busy, 1 + ((m == 0) ? 7 : 4 - m) + 3, "R7 setup and recovery kept");
      end

    // R9: request held while busy, begins right after recovery
    emode_i = 8'h00;
    setup_i = {2'd1, 2'd3};
    rd_tim_i = {8'h00, 8'h59};
    wr_tim_i = {8'h24, 8'h00};
    run(1'b0, 1'b0, 1, -1, 1'b1, 1'b1);
    chk(m_pulses, 2, "R9 queued strobe count");
    chk(m_first2, 3 + 6 + 10 + 1, "R9 queued start without gap");
    chk(m_plen1, 3, "R9 queued strobe width");
    chk(m_busy, 19 + 1 + 3 + 5, "R9 continuous busy");
    chk(m_wr, 3, "R9 queued direction");

    // R9: start sampled at the last recovery edge
    run(1'b0, 1'b0, 18, -1, 1'b1, 1'b1);
    chk(m_first2, 20, "R9 start at recovery end");
    chk(m_busy, 28, "R9 start at recovery end busy");

    // R10: second request while one is held is dropped
    run(1'b0, 1'b0, 1, 4, 1'b1, 1'b1);
    chk(m_pulses, 2, "R10 extra request dropped");
    chk(m_busy, 28, "R10 busy without extra cycle");

    @(negedge clk);
    chk(busy_o, 0, "R8 idle at end");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule